// File: doc/BRIEF.md
# Serial Configuration Stream Loader

This block loads a programmable target device through its one-bit serial configuration port. A host hands it a stream of bytes over a valid/ready interface, with a flag on the final byte. The block then produces the device-side handshake. It drives the active-low program request and waits for the device to report that it is clearing. It releases the request and waits for the device to report that it is ready. It then shifts every byte onto the data line, high bit first, with a configuration clock whose low and high phases each last a set number of system clocks.

The block checks the device status lines before it takes each byte. If the device pulls its init line low while its done line is still low, it has detected a checksum error, and the load stops with an error code. After the final byte the data line stays high and clock pulses continue until the device raises done. Each wait on the device is bounded by a cycle timeout, which by default is one hundredth of the system clock frequency. Both device status inputs pass through a synchronizer of configurable depth.

Top module: `cfg_serial_loader`

## Requirements
- R1: A pulse on `ld_start` while idle drives `cfg_prog_n` low. It stays low until the synchronized `cfg_init_n` reads low, and it is then released. Exactly one program pulse is made per load.
- R2: If `cfg_init_n` does not go low within `TIMEOUT_CYC` cycles of the program request, the load ends with `ld_err`=1 and `ld_err_code`=0. No configuration clock edge is issued.
- R3: After release, no rising edge appears on `cfg_cclk` until `cfg_init_n` reads high. If it stays low for `TIMEOUT_CYC` cycles, the load ends with `ld_err`=1 and `ld_err_code`=1.
- R4: Each accepted byte appears on `cfg_dout` most significant bit first. Each bit is stable across the rising edge of `cfg_cclk`, so a device sampling on rising edges receives the bytes unchanged.
- R5: Each low phase of `cfg_cclk` lasts exactly `LOW_CYC` system clocks. Each high phase lasts at least `HIGH_CYC` system clocks.
- R6: A byte is accepted only on a cycle with `host_valid` and `host_ready` both high. `host_ready` is high only while the block waits for the next byte and no checksum error is flagged. Every byte of a load up to the final one is accepted exactly once.
- R7: When the block is waiting for a byte and sees `cfg_init_n` low with `cfg_done` low, the load ends with `ld_err`=1 and `ld_err_code`=2. The byte on offer in that cycle is not accepted.
- R8: After the byte marked by `host_last`, `cfg_dout` stays 1 and clock pulses continue until `cfg_done` reads high. The load then ends with `ld_ok`=1, and no further pulse follows.
- R9: If `cfg_done` stays low for `TIMEOUT_CYC` cycles after the final byte, the load ends with `ld_err`=1 and `ld_err_code`=3.
- R10: `ld_busy` is high from the start pulse until the load ends. `ld_ok` and `ld_err` are cleared at start, are never high together, and hold their values until the next start. A start pulse during a load is ignored.
- R11: After reset, `cfg_prog_n`=1, `cfg_cclk`=1, `cfg_dout`=1, `host_ready`=0, `ld_busy`=0, `ld_ok`=0 and `ld_err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_start | input | 1 | Begin a load (sampled while idle) |
| host_valid | input | 1 | Host offers a byte |
| host_data | input | WORD_W | Byte offered by the host |
| host_last | input | 1 | Offered byte is the final one |
| host_ready | output | 1 | Block accepts the offered byte this cycle |
| ld_busy | output | 1 | A load is in progress |
| ld_ok | output | 1 | Last load finished with done high |
| ld_err | output | 1 | Last load failed |
| ld_err_code | output | 2 | 0 clear timeout, 1 ready timeout, 2 checksum error, 3 done timeout |
| cfg_prog_n | output | 1 | Program request to device, active low |
| cfg_init_n | input | 1 | Device init line, low while clearing or on error |
| cfg_done | input | 1 | Device done line |
| cfg_cclk | output | 1 | Configuration clock, device samples on rising edge |
| cfg_dout | output | 1 | Serial configuration data |

## Verification
Two events can land in the same cycle: the checksum-error check and the acceptance of the next byte. Both act in the cycle when the block starts waiting for a byte. The bench's device model pulls init low right after the last rising edge of a chosen byte, while the host driver already holds the next byte valid. The result is judged at the ports. The error code must be 2, and the count of bytes the driver saw accepted must equal the chosen byte's index, so the contested byte was never taken. A second overlap, between done rising and the next clock pulse starting, is judged by requiring that the number of flush pulses equals the pulse count after which the model raised done.

// File: rtl/cfgl_pkg.sv
`timescale 1ns/1ps
package cfgl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_PROG  = 3'd1,
      ST_WAKE  = 3'd2,
      ST_BYTE  = 3'd3,
      ST_SHIFT = 3'd4,
      ST_FLUSH = 3'd5
   } ld_state_t;

   typedef enum logic [1:0] {
      FAIL_CLEAR = 2'd0,
      FAIL_WAKE  = 2'd1,
      FAIL_CRC   = 2'd2,
      FAIL_DONE  = 2'd3
   } fail_code_t;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_LOW  = 2'd1,
      PH_HIGH = 2'd2
   } clk_phase_t;

endpackage

// File: rtl/cfgl_sync.sv
`timescale 1ns/1ps
module cfgl_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES < 1) begin : g_bad_depth
         $error("cfgl_sync: STAGES must be at least 1");
      end
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= RST_VAL;
            else        chain_q <= d;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= {STAGES{RST_VAL}};
            else        chain_q <= {chain_q[STAGES-2:0], d};
         end
      end
   endgenerate

   assign q = chain_q[STAGES-1];

endmodule

// File: rtl/cfgl_wait_timer.sv
`timescale 1ns/1ps
module cfgl_wait_timer #(
   parameter int unsigned LIMIT = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic expired
);

   localparam int unsigned CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);

   generate
      if (LIMIT < 1) begin : g_bad_limit
         $error("cfgl_wait_timer: LIMIT must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      cnt_q <= '0;
      else if (clr)                    cnt_q <= '0;
      else if (cnt_q != CW'(LIMIT))    cnt_q <= cnt_q + 1'b1;
   end

   assign expired = (cnt_q == CW'(LIMIT));

   // once reached, the limit holds until the next clear
   p_expiry_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (expired && !clr) |=> expired);

endmodule

// File: rtl/cfgl_bit_clock.sv
`timescale 1ns/1ps
module cfgl_bit_clock
   import cfgl_pkg::*;
#(
   parameter int unsigned LOW_CYC  = 2,
   parameter int unsigned HIGH_CYC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic more,
   output logic cclk,
   output logic bit_end
);

   localparam int unsigned MAXP = (LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC;
   localparam int unsigned CW   = (MAXP < 2) ? 1 : $clog2(MAXP);

   generate
      if (LOW_CYC < 1 || HIGH_CYC < 1) begin : g_bad_phase
         $error("cfgl_bit_clock: phase lengths must be at least 1");
      end
   endgenerate

   clk_phase_t    ph_q, ph_d;
   logic [CW-1:0] cnt_q, cnt_d;
   logic          cclk_q;

   always_comb begin
      ph_d  = ph_q;
      cnt_d = cnt_q;
      if (!run) begin
         ph_d  = PH_IDLE;
         cnt_d = '0;
      end else begin
         case (ph_q)
            PH_IDLE: begin
               ph_d  = PH_LOW;
               cnt_d = '0;
            end
            PH_LOW: begin
               if (cnt_q == CW'(LOW_CYC - 1)) begin
                  ph_d  = PH_HIGH;
                  cnt_d = '0;
               end else begin
                  cnt_d = cnt_q + 1'b1;
               end
            end
            PH_HIGH: begin
               if (cnt_q == CW'(HIGH_CYC - 1)) begin
                  ph_d  = more ? PH_LOW : PH_IDLE;
                  cnt_d = '0;
               end else begin
                  cnt_d = cnt_q + 1'b1;
               end
            end
            default: begin
               ph_d  = PH_IDLE;
               cnt_d = '0;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q   <= PH_IDLE;
         cnt_q  <= '0;
         cclk_q <= 1'b1;
      end else begin
         ph_q   <= ph_d;
         cnt_q  <= cnt_d;
         cclk_q <= (ph_d != PH_LOW);
      end
   end

   assign cclk    = cclk_q;
   assign bit_end = run && (ph_q == PH_HIGH) && (cnt_q == CW'(HIGH_CYC - 1));

   p_low_bounded_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_LOW) |-> (cnt_q < CW'(LOW_CYC)));

   p_fall_needs_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cclk_q) |-> $past(run));

endmodule

// File: rtl/cfgl_shifter.sv
`timescale 1ns/1ps
module cfgl_shifter #(
   parameter int unsigned WORD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WORD_W-1:0] din,
   input  logic              shift,
   output logic              bit_o,
   output logic              last_bit
);

   localparam int unsigned CW = $clog2(WORD_W + 1);

   generate
      if (WORD_W < 2) begin : g_bad_width
         $error("cfgl_shifter: WORD_W must be at least 2");
      end
   endgenerate

   logic [WORD_W-1:0] sr_q;
   logic [CW-1:0]     left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q   <= '0;
         left_q <= '0;
      end else if (load) begin
         sr_q   <= din;
         left_q <= CW'(WORD_W);
      end else if (shift) begin
         sr_q   <= {sr_q[WORD_W-2:0], 1'b0};
         left_q <= left_q - 1'b1;
      end
   end

   assign bit_o    = sr_q[WORD_W-1];
   assign last_bit = (left_q == CW'(1));

   p_shift_has_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
      shift |-> (left_q != '0));

   p_count_bounded_r4: assert property (@(posedge clk) disable iff (!rst_n)
      left_q <= CW'(WORD_W));

endmodule

// File: rtl/cfg_serial_loader.sv
`timescale 1ns/1ps
module cfg_serial_loader
   import cfgl_pkg::*;
#(
   parameter int unsigned CLK_HZ      = 100_000_000,
   parameter int unsigned TIMEOUT_CYC = CLK_HZ / 100,
   parameter int unsigned LOW_CYC     = 2,
   parameter int unsigned HIGH_CYC    = 3,
   parameter int unsigned WORD_W      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_start,
   input  logic              host_valid,
   input  logic [WORD_W-1:0] host_data,
   input  logic              host_last,
   output logic              host_ready,
   output logic              ld_busy,
   output logic              ld_ok,
   output logic              ld_err,
   output logic [1:0]        ld_err_code,
   output logic              cfg_prog_n,
   input  logic              cfg_init_n,
   input  logic              cfg_done,
   output logic              cfg_cclk,
   output logic              cfg_dout
);

   generate
      if (HIGH_CYC <= SYNC_STAGES) begin : g_bad_sync
         $error("cfg_serial_loader: HIGH_CYC must exceed SYNC_STAGES");
      end
   endgenerate

   ld_state_t  state_q, state_d;
   fail_code_t code_q, code_d;
   logic init_s, done_s;
   logic tmr_clr, tmr_exp;
   logic clk_run, clk_more, bit_end;
   logic sh_bit, last_bit, accept, crc_hit;
   logic last_q, ok_q, err_q, prog_n_q;
   logic set_ok, set_fail;

   cfgl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_init (
      .clk(clk), .rst_n(rst_n), .d(cfg_init_n), .q(init_s));

   cfgl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_done (
      .clk(clk), .rst_n(rst_n), .d(cfg_done), .q(done_s));

   cfgl_wait_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
      .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .expired(tmr_exp));

   cfgl_bit_clock #(.LOW_CYC(LOW_CYC), .HIGH_CYC(HIGH_CYC)) u_bitclk (
      .clk(clk), .rst_n(rst_n), .run(clk_run), .more(clk_more),
      .cclk(cfg_cclk), .bit_end(bit_end));

   cfgl_shifter #(.WORD_W(WORD_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .load(accept), .din(host_data),
      .shift(bit_end && (state_q == ST_SHIFT)),
      .bit_o(sh_bit), .last_bit(last_bit));

   assign crc_hit = !init_s && !done_s;

   always_comb begin
      state_d  = state_q;
      code_d   = code_q;
      accept   = 1'b0;
      set_ok   = 1'b0;
      set_fail = 1'b0;
      case (state_q)
         ST_IDLE: begin
            if (ld_start) state_d = ST_PROG;
         end
         ST_PROG: begin
            if (!init_s) begin
               state_d = ST_WAKE;
            end else if (tmr_exp) begin
               set_fail = 1'b1;
               code_d   = FAIL_CLEAR;
            end
         end
         ST_WAKE: begin
            if (init_s) begin
               state_d = ST_BYTE;
            end else if (tmr_exp) begin
               set_fail = 1'b1;
               code_d   = FAIL_WAKE;
            end
         end
         ST_BYTE: begin
            if (crc_hit) begin
               set_fail = 1'b1;
               code_d   = FAIL_CRC;
            end else if (host_valid) begin
               accept  = 1'b1;
               state_d = ST_SHIFT;
            end
         end
         ST_SHIFT: begin
            if (bit_end && last_bit) state_d = last_q ? ST_FLUSH : ST_BYTE;
         end
         ST_FLUSH: begin
            if (done_s) begin
               set_ok = 1'b1;
            end else if (tmr_exp) begin
               set_fail = 1'b1;
               code_d   = FAIL_DONE;
            end
         end
         default: state_d = ST_IDLE;
      endcase
      if (set_ok || set_fail) state_d = ST_IDLE;
   end

   assign tmr_clr  = (state_d != state_q);
   assign clk_run  = (state_q == ST_SHIFT) || (state_q == ST_FLUSH);
   assign clk_more = (state_q == ST_SHIFT) ? (!last_bit || last_q)
                                           : (!done_s && !tmr_exp);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         last_q   <= 1'b0;
         ok_q     <= 1'b0;
         err_q    <= 1'b0;
         code_q   <= FAIL_CLEAR;
         prog_n_q <= 1'b1;
      end else begin
         state_q  <= state_d;
         prog_n_q <= (state_d != ST_PROG);
         if (accept) last_q <= host_last;
         if ((state_q == ST_IDLE) && ld_start) begin
            ok_q  <= 1'b0;
            err_q <= 1'b0;
         end else if (set_ok) begin
            ok_q <= 1'b1;
         end else if (set_fail) begin
            err_q  <= 1'b1;
            code_q <= code_d;
         end
      end
   end

   assign host_ready  = (state_q == ST_BYTE) && !crc_hit;
   assign ld_busy     = (state_q != ST_IDLE);
   assign ld_ok       = ok_q;
   assign ld_err      = err_q;
   assign ld_err_code = code_q;
   assign cfg_prog_n  = prog_n_q;
   assign cfg_dout    = (state_q == ST_SHIFT) ? sh_bit : 1'b1;

   p_no_clock_in_prog_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_prog_n |-> cfg_cclk);

   p_ready_in_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
      host_ready |-> (ld_busy && cfg_prog_n));

   p_take_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (host_valid && host_ready) |=> !host_ready);

   p_crc_from_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ld_err) && (ld_err_code == 2'd2)) |-> ($past(state_q) == ST_BYTE));

   p_status_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(ld_ok && ld_err));

   p_busy_clears_status_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ld_busy |-> (!ld_ok && !ld_err));

endmodule

// File: tb/test_cfg_serial_loader.sv
`timescale 1ns/1ps
module test_cfg_serial_loader;

   localparam int W     = 8;
   localparam int LOWC  = 2;
   localparam int HIGHC = 4;
   localparam int TOC   = 300;
   localparam int SYNC  = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic         ld_start = 1'b0, host_valid = 1'b0, host_last = 1'b0;
   logic [W-1:0] host_data = '0;
   logic         host_ready, ld_busy, ld_ok, ld_err;
   logic [1:0]   ld_err_code;
   logic         cfg_prog_n, cfg_cclk, cfg_dout;
   logic         init_n_m, done_m;

   cfg_serial_loader #(.CLK_HZ(200_000_000), .TIMEOUT_CYC(TOC), .LOW_CYC(LOWC),
      .HIGH_CYC(HIGHC), .WORD_W(W), .SYNC_STAGES(SYNC)) i_cfg_serial_loader (
      .clk(clk), .rst_n(rst_n), .ld_start(ld_start), .host_valid(host_valid),
      .host_data(host_data), .host_last(host_last), .host_ready(host_ready),
      .ld_busy(ld_busy), .ld_ok(ld_ok), .ld_err(ld_err), .ld_err_code(ld_err_code),
      .cfg_prog_n(cfg_prog_n), .cfg_init_n(init_n_m), .cfg_done(done_m),
      .cfg_cclk(cfg_cclk), .cfg_dout(cfg_dout));

   // device model controls
   int m_bits = 0, m_crc_byte = 0, m_done_after = 1;
   bit m_no_clear = 0, m_no_ready = 0, m_no_done = 0;
   // device model observations
   logic [7:0] rxbuf [0:15];
   logic [7:0] txbuf [0:15];
   int rxn, flushc, bad_flush, early, wake_cnt, prog_falls;
   bit crc_set;
   logic cclk_prev, prog_prev;

   always @(posedge clk) begin
      if (!rst_n) begin
         init_n_m <= 1'b1; done_m <= 1'b0; wake_cnt <= 0; rxn <= 0; flushc <= 0;
         bad_flush <= 0; early <= 0; crc_set <= 0; cclk_prev <= 1'b1;
         prog_prev <= 1'b1; prog_falls <= 0;
      end else begin
         cclk_prev <= cfg_cclk;
         prog_prev <= cfg_prog_n;
         if (prog_prev && !cfg_prog_n) prog_falls <= prog_falls + 1;
         if (!cfg_prog_n) begin
            init_n_m <= m_no_clear; done_m <= 1'b0; wake_cnt <= 0; rxn <= 0;
            flushc <= 0; bad_flush <= 0; early <= 0; crc_set <= 0;
         end else begin
            if (!init_n_m && !crc_set && !m_no_ready) begin
               if (wake_cnt == 5) init_n_m <= 1'b1;
               wake_cnt <= wake_cnt + 1;
            end
            if (!cclk_prev && cfg_cclk) begin
               if (!init_n_m && !crc_set) early <= early + 1;
               if (rxn < m_bits) begin
                  rxbuf[rxn/8] <= {rxbuf[rxn/8][6:0], cfg_dout};
                  rxn <= rxn + 1;
                  if (m_crc_byte > 0 && rxn + 1 == m_crc_byte * 8) begin
                     init_n_m <= 1'b0; crc_set <= 1'b1;
                  end
               end else begin
                  flushc <= flushc + 1;
                  if (!cfg_dout) bad_flush <= bad_flush + 1;
                  if (!m_no_done && flushc + 1 >= m_done_after) done_m <= 1'b1;
               end
            end
         end
      end
   end

   // clock phase monitor
   int run_len = 0, low_bad = 0, high_bad = 0;
   logic mon_prev = 1'b1;
   bit mon_en = 1'b1;
   always @(negedge clk) begin
      if (rst_n) begin
         if (cfg_cclk == mon_prev) run_len++;
         else begin
            if (mon_en && !mon_prev && run_len != LOWC) low_bad++;
            if (mon_en && mon_prev && run_len < HIGHC) high_bad++;
            run_len = 1;
         end
         mon_prev = cfg_cclk;
      end
   end

   int n_chk = 0, n_bad = 0, accepted = 0;
   bit finished = 0;

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic finish_up();
      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   endtask

   task automatic run_load(input int n, input int crc_byte, input bit no_clear,
                           input bit no_ready, input bit no_done, input int done_after,
                           input bit poke);
      m_bits = n * 8; m_crc_byte = crc_byte; m_no_clear = no_clear;
      m_no_ready = no_ready; m_no_done = no_done; m_done_after = done_after;
      accepted = 0;
      @(negedge clk); ld_start = 1'b1;
      @(negedge clk); ld_start = 1'b0;
      chk("R10", "busy after start", ld_busy, 1);
      chk("R10", "status cleared at start", ld_ok | ld_err, 0);
      for (int i = 0; i < n; i++) begin
         host_valid = 1'b1; host_data = txbuf[i]; host_last = (i == n - 1);
         do @(negedge clk); while (!host_ready && ld_busy);
         if (!host_ready) break;
         accepted++;
         @(negedge clk);
         if (poke && i == 0) begin
            ld_start = 1'b1; @(negedge clk); ld_start = 1'b0;
         end
      end
      host_valid = 1'b0; host_last = 1'b0;
      while (ld_busy) @(negedge clk);
   endtask

   function automatic int exp_code(input bit nc, input bit nr, input int cb, input bit nd);
      if (nc) return 0;
      if (nr) return 1;
      if (cb > 0) return 2;
      if (nd) return 3;
      return -1;
   endfunction

   task automatic check_good(input string tag, input int n, input int da);
      chk("R8", {tag, " ok"}, ld_ok, 1);
      chk("R10", {tag, " no error"}, ld_err, 0);
      chk("R6", {tag, " bytes accepted"}, accepted, n);
      for (int i = 0; i < n; i++) chk("R4", {tag, " byte data"}, rxbuf[i], txbuf[i]);
      chk("R8", {tag, " flush pulses"}, flushc, da);
      chk("R8", {tag, " flush data high"}, bad_flush, 0);
      chk("R3", {tag, " no early clock"}, early, 0);
   endtask

   initial begin
      void'($urandom(32'd4021));
      repeat (4) @(negedge clk);
      // R11: reset values
      chk("R11", "prog_n", cfg_prog_n, 1);
      chk("R11", "cclk", cfg_cclk, 1);
      chk("R11", "dout", cfg_dout, 1);
      chk("R11", "ready", host_ready, 0);
      chk("R11", "busy", ld_busy, 0);
      chk("R11", "ok/err", {ld_ok, ld_err}, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // directed: single byte
      txbuf[0] = 8'hA5;
      run_load(1, 0, 0, 0, 0, 1, 0);
      check_good("single", 1, 1);
      chk("R1", "one program pulse", prog_falls, 1);

      // directed edge patterns
      txbuf[0] = 8'h00; txbuf[1] = 8'hFF; txbuf[2] = 8'h01; txbuf[3] = 8'h80;
      run_load(4, 0, 0, 0, 0, 3, 0);
      check_good("patterns", 4, 3);
      chk("R1", "program pulses", prog_falls, 2);
      repeat (10) @(negedge clk);
      chk("R10", "ok sticky", ld_ok, 1);

      // random loads
      for (int k = 0; k < 5; k++) begin
         int n  = int'($urandom_range(2, 8));
         int da = int'($urandom_range(1, 5));
         for (int i = 0; i < n; i++) txbuf[i] = 8'($urandom_range(0, 255));
         run_load(n, 0, 0, 0, 0, da, 0);
         check_good("random", n, da);
      end

      // R10: start during a load is ignored
      for (int i = 0; i < 3; i++) txbuf[i] = 8'(8'h3C + i);
      run_load(3, 0, 0, 0, 0, 2, 1);
      check_good("poke", 3, 2);

      // R2: device never clears
      run_load(2, 0, 1, 0, 0, 1, 0);
      chk("R2", "error flag", ld_err, 1);
      chk("R2", "code", ld_err_code, exp_code(1, 0, 0, 0));
      chk("R2", "no clock pulses", rxn + flushc, 0);

      // R3: device never ready
      run_load(2, 0, 0, 1, 0, 1, 0);
      chk("R3", "error flag", ld_err, 1);
      chk("R3", "code", ld_err_code, exp_code(0, 1, 0, 0));
      chk("R3", "no clock pulses", rxn + flushc + early, 0);
      chk("R6", "nothing accepted", accepted, 0);

      // R7: checksum error races with the next byte on offer
      for (int i = 0; i < 4; i++) txbuf[i] = 8'($urandom_range(0, 255));
      run_load(4, 2, 0, 0, 0, 1, 0);
      chk("R7", "error flag", ld_err, 1);
      chk("R7", "code", ld_err_code, exp_code(0, 0, 2, 0));
      chk("R7", "contested byte not taken", accepted, 2);
      chk("R7", "ok low", ld_ok, 0);

      // R9: done never rises
      mon_en = 1'b0;
      txbuf[0] = 8'h5A;
      run_load(1, 0, 0, 0, 1, 1, 0);
      chk("R9", "error flag", ld_err, 1);
      chk("R9", "code", ld_err_code, exp_code(0, 0, 0, 1));
      chk("R8", "flush data high on timeout", bad_flush, 0);
      chk("R9", "flush pulses issued", int'(flushc > 0), 1);
      repeat (20) @(negedge clk);
      mon_en = 1'b1;

      // recovery after errors
      txbuf[0] = 8'hC3; txbuf[1] = 8'h7E;
      run_load(2, 0, 0, 0, 0, 4, 0);
      check_good("recover", 2, 4);

      chk("R5", "low phase length", low_bad, 0);
      chk("R5", "high phase length", high_bad, 0);
      finish_up();
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_up();
   end

endmodule